// File: doc/BRIEF.md
# Direction-Gated GPIO Register Bank

This block is the register side of a 32-pin general-purpose I/O port sitting on a plain word-wide register bus. It keeps a pin level register, a per-pin direction register and a general scratch register. The level register cannot be written directly. Software raises and lowers output pins through a dedicated set address and a dedicated clear address. Every bit of those writes is masked by the direction register, so a pin configured as an input can never be changed.

A set or clear write whose data reaches no output pin changes nothing and is reported on a one-cycle error strobe. The same strobe reports any access that the block cannot serve:
- an address with no register behind it,
- a write to the read-only level address,
- a read of a write-only address,
- a transfer narrower than a full word.

The three edge-control addresses accept writes without error and without effect, so that existing driver code runs unchanged. Read data is registered and appears one cycle after the read strobe. The level and direction registers are also driven out as ports, for the pad logic that sits outside this block.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous reset, `pin_level`, `pin_dir`, the scratch register and `err_pulse` are all zero.
- R2: A full-word write to offset 0x04 loads the direction register, where bit value 1 means output. Its value appears on `pin_dir` and reads back at 0x04. Changing the direction leaves the level register unchanged.
- R3: A full-word write to offset 0x20 loads the scratch register, and a read of 0x20 returns the value written.
- R4: A full-word write to offset 0x08 ORs (write data AND direction) into the level register. A read of 0x00 returns the level register.
- R5: A full-word write to offset 0x0C clears, in the level register, the bits of (write data AND direction).
- R6: A set or clear write whose data has no bit in common with the direction register leaves the level register unchanged and pulses `err_pulse`.
- R7: A set or clear write that touches both input and output pins changes only the output pins and raises no error.
- R8: Full-word writes to offsets 0x10, 0x14 and 0x18 raise no error and change no register.
- R9: Every other access is rejected and pulses `err_pulse`; a rejected read returns zero. This covers writes to 0x00, to undecoded offsets and to misaligned offsets, and reads of any offset other than 0x00, 0x04 and 0x20.
- R10: An access whose byte enables are not all ones is rejected: a write is dropped, a read returns zero, and `err_pulse` pulses.
- R11: `err_pulse` is high for exactly the one cycle after the offending strobe. `rdata` updates on the clock edge that samples `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the access |
| be | input | W/8 | Byte enables; all ones for a valid access |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data, valid the cycle after `rd_en` |
| err_pulse | output | 1 | One-cycle strobe flagging a rejected access |
| pin_level | output | W | Current level register, toward the pad logic |
| pin_dir | output | W | Current direction register, 1 = output |

## Verification
Set and clear data are applied in three forms against the direction mask: entirely inside the output pins, entirely on input pins, and straddling both. These separate proper masking from a design that ignores direction, from one that rejects mixed writes, and from one that flags only partial misses. The direction is later flipped from the low half to the high half. This shows that level bits survive a direction change and that masking follows the current direction rather than the one in force at reset. The edge addresses, the read-only level address, the undecoded and misaligned offsets and the partial byte enables are each tried on both reads and writes. This shows that each address class lands in its own accept or reject path.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register offsets; software depends on these values.
  localparam int unsigned OFS_LEVEL = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_SET   = 'h08;
  localparam int unsigned OFS_CLR   = 'h0C;
  localparam int unsigned OFS_EDGE0 = 'h10;
  localparam int unsigned OFS_EDGE1 = 'h14;
  localparam int unsigned OFS_EDGE2 = 'h18;
  localparam int unsigned OFS_SPARE = 'h20;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_EDGE,
    SEL_SPARE,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if      (addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_SET))   sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
    else if (addr == ADDR_W'(OFS_EDGE0) ||
             addr == ADDR_W'(OFS_EDGE1) ||
             addr == ADDR_W'(OFS_EDGE2)) sel = SEL_EDGE;
    else if (addr == ADDR_W'(OFS_SPARE)) sel = SEL_SPARE;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_level_ctrl.sv
module gpio_level_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] data,
  input  logic [W-1:0] dir,
  output logic [W-1:0] level,
  output logic         no_target
);

  logic [W-1:0] hit;

  // Only output pins are eligible for a change.
  assign hit       = data & dir;
  assign no_target = (set_stb || clr_stb) && (hit == '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                       level[i] <= 1'b0;
      else if (set_stb && hit[i])    level[i] <= 1'b1;
      else if (clr_stb && hit[i])    level[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_stb,
  input  reg_sel_e     sel,
  input  logic [W-1:0] level,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] spare,
  output logic [W-1:0] rdata
);

  logic [W-1:0] mux_q;

  always_comb begin
    unique case (sel)
      SEL_LEVEL: mux_q = level;
      SEL_DIR:   mux_q = dir;
      SEL_SPARE: mux_q = spare;
      default:   mux_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_stb) rdata <= mux_q;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W/8-1:0]    be,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              err_pulse,
  output logic [W-1:0]      pin_level,
  output logic [W-1:0]      pin_dir
);

  localparam int BE_W = W / 8;

  reg_sel_e     sel_raw;
  reg_sel_e     sel;
  logic         word_ok;
  logic         set_stb;
  logic         clr_stb;
  logic         no_target;
  logic         wr_bad;
  logic         rd_bad;
  logic [W-1:0] spare_q;

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel_raw)
  );

  // A narrow transfer is treated as an access to nothing.
  assign word_ok = (be == {BE_W{1'b1}});
  assign sel     = word_ok ? sel_raw : SEL_NONE;

  assign set_stb = wr_en && (sel == SEL_SET);
  assign clr_stb = wr_en && (sel == SEL_CLR);

  gpio_level_ctrl #(.W(W)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .set_stb   (set_stb),
    .clr_stb   (clr_stb),
    .data      (wdata),
    .dir       (pin_dir),
    .level     (pin_level),
    .no_target (no_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_dir <= '0;
      spare_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_DIR)   pin_dir <= wdata;
      if (sel == SEL_SPARE) spare_q <= wdata;
    end
  end

  gpio_bank_rdmux #(.W(W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_stb (rd_en),
    .sel    (sel),
    .level  (pin_level),
    .dir    (pin_dir),
    .spare  (spare_q),
    .rdata  (rdata)
  );

  assign wr_bad = wr_en && ((sel == SEL_NONE) || (sel == SEL_LEVEL) || no_target);
  assign rd_bad = rd_en && !((sel == SEL_LEVEL) || (sel == SEL_DIR) || (sel == SEL_SPARE));

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= wr_bad || rd_bad;
  end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W/8-1:0]    be,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      rdata,
  input logic              err_pulse,
  input logic [W-1:0]      pin_level,
  input logic [W-1:0]      pin_dir
);

  logic full;
  logic is_set;
  logic is_clr;
  logic is_edge;
  logic readable;

  assign full     = &be;
  assign is_set   = addr == ADDR_W'(OFS_SET);
  assign is_clr   = addr == ADDR_W'(OFS_CLR);
  assign is_edge  = addr == ADDR_W'(OFS_EDGE0) || addr == ADDR_W'(OFS_EDGE1) ||
                    addr == ADDR_W'(OFS_EDGE2);
  assign readable = addr == ADDR_W'(OFS_LEVEL) || addr == ADDR_W'(OFS_DIR) ||
                    addr == ADDR_W'(OFS_SPARE);

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (pin_level == '0 && pin_dir == '0 && !err_pulse));

  a_r4_set_or: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && is_set) |=>
      pin_level == ($past(pin_level) | ($past(wdata) & $past(pin_dir))));

  a_r5_clr_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && is_clr) |=>
      pin_level == ($past(pin_level) & ~($past(wdata) & $past(pin_dir))));

  a_r6_miss_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && (is_set || is_clr) && ((wdata & pin_dir) == '0)) |=>
      (err_pulse && $stable(pin_level)));

  a_r7_inputs_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pin_level ^ $past(pin_level)) & ~$past(pin_dir)) == '0);

  a_r8_edge_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && full && is_edge) |=>
      (!err_pulse && $stable(pin_level) && $stable(pin_dir)));

  a_r9_bad_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !readable) |=> (rdata == '0 && err_pulse));

  a_r10_narrow: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !full) |=> (err_pulse && $stable(pin_level) && $stable(pin_dir)));

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> (!err_pulse && $stable(rdata)));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .be        (be),
  .wdata     (wdata),
  .rdata     (rdata),
  .err_pulse (err_pulse),
  .pin_level (pin_level),
  .pin_dir   (pin_dir)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

  localparam int W      = 32;
  localparam int ADDR_W = 8;
  localparam int NV     = 22;

  typedef struct packed {
    logic        rd;       // 1 = read (check rdata), 0 = write (check pin_level)
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h04, 4'hF, 32'h0000_FFFF, 32'h0000_0000, 1'b0, 4'd2},  // R2 dir low half
    '{1'b1, 8'h04, 4'hF, 32'h0,         32'h0000_FFFF, 1'b0, 4'd2},  // R2 read back
    '{1'b0, 8'h08, 4'hF, 32'hA5A5_A5A5, 32'h0000_A5A5, 1'b0, 4'd7},  // R7 mixed set
    '{1'b1, 8'h00, 4'hF, 32'h0,         32'h0000_A5A5, 1'b0, 4'd4},  // R4 read level
    '{1'b0, 8'h0C, 4'hF, 32'h0000_00FF, 32'h0000_A500, 1'b0, 4'd5},  // R5 clear
    '{1'b0, 8'h08, 4'hF, 32'hFFFF_0000, 32'h0000_A500, 1'b1, 4'd6},  // R6 set miss
    '{1'b0, 8'h0C, 4'hF, 32'h0F0F_0000, 32'h0000_A500, 1'b1, 4'd6},  // R6 clear miss
    '{1'b0, 8'h10, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b0, 4'd8},  // R8
    '{1'b0, 8'h14, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b0, 4'd8},  // R8
    '{1'b0, 8'h18, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b0, 4'd8},  // R8
    '{1'b0, 8'h20, 4'hF, 32'h1234_5678, 32'h0000_A500, 1'b0, 4'd3},  // R3
    '{1'b1, 8'h20, 4'hF, 32'h0,         32'h1234_5678, 1'b0, 4'd3},  // R3 read back
    '{1'b0, 8'h00, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b1, 4'd9},  // R9 level is read-only
    '{1'b1, 8'h24, 4'hF, 32'h0,         32'h0000_0000, 1'b1, 4'd9},  // R9 undecoded read
    '{1'b0, 8'h42, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b1, 4'd9},  // R9 misaligned write
    '{1'b1, 8'h10, 4'hF, 32'h0,         32'h0000_0000, 1'b1, 4'd9},  // R9 write-only read
    '{1'b0, 8'h04, 4'h3, 32'h0000_0000, 32'h0000_A500, 1'b1, 4'd10}, // R10 narrow write
    '{1'b1, 8'h04, 4'hF, 32'h0,         32'h0000_FFFF, 1'b0, 4'd10}, // R10 dir kept
    '{1'b1, 8'h04, 4'h7, 32'h0,         32'h0000_0000, 1'b1, 4'd10}, // R10 narrow read
    '{1'b0, 8'h04, 4'hF, 32'hFFFF_0000, 32'h0000_A500, 1'b0, 4'd2},  // R2 dir flip keeps level
    '{1'b0, 8'h0C, 4'hF, 32'hFFFF_FFFF, 32'h0000_A500, 1'b0, 4'd7},  // R7 mixed clear
    '{1'b0, 8'h08, 4'hF, 32'h00FF_00FF, 32'h00FF_A500, 1'b0, 4'd7}   // R7 mixed set
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [W/8-1:0]    be = '0;
  logic [W-1:0]      wdata = '0;
  logic [W-1:0]      rdata;
  logic              err_pulse;
  logic [W-1:0]      pin_level;
  logic [W-1:0]      pin_dir;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpio_port_regs #(.W(W), .ADDR_W(ADDR_W)) u_gpio_port_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .be        (be),
    .wdata     (wdata),
    .rdata     (rdata),
    .err_pulse (err_pulse),
    .pin_level (pin_level),
    .pin_dir   (pin_dir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access at a falling edge; outputs are sampled at the next falling edge.
  task automatic access(input logic rd, input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d);
    @(negedge clk);
    wr_en = !rd;
    rd_en = rd;
    addr  = a;
    be    = b;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 level", pin_level, 32'h0);
    check("R1 dir", pin_dir, 32'h0);
    check("R1 err", {31'h0, err_pulse}, 32'h0);
    access(1'b1, 8'h20, 4'hF, 32'h0);
    check("R1 spare", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].rd, TBL[i].addr, TBL[i].be, TBL[i].data);
      if (TBL[i].rd)
        check($sformatf("R%0d vec%0d rdata", TBL[i].req, i), rdata, TBL[i].exp);
      else
        check($sformatf("R%0d vec%0d level", TBL[i].req, i), pin_level, TBL[i].exp);
      check($sformatf("R%0d vec%0d err", TBL[i].req, i), {31'h0, err_pulse},
            {31'h0, TBL[i].exp_err});
    end

    // R11: error strobe lasts one cycle, read data holds while idle
    access(1'b1, 8'h00, 4'hF, 32'h0);
    access(1'b0, 8'h30, 4'hF, 32'h1);
    check("R11 err high", {31'h0, err_pulse}, 32'h1);
    @(negedge clk);
    check("R11 err low", {31'h0, err_pulse}, 32'h0);
    check("R11 rdata held", rdata, 32'h00FF_A500);

    // R1: reset in mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 level after reset", pin_level, 32'h0);
    check("R1 dir after reset", pin_dir, 32'h0);
    access(1'b1, 8'h20, 4'hF, 32'h0);
    check("R1 spare after reset", rdata, 32'h0);

    // R6: with every pin an input, a set is a miss
    access(1'b0, 8'h08, 4'hF, 32'hFFFF_FFFF);
    check("R6 all-input level", pin_level, 32'h0);
    check("R6 all-input err", {31'h0, err_pulse}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule